// File: doc/BRIEF.md
# Load/Store Address Router and Byte-Lane Unit

This unit sits between the execute stage of a small 32-bit core and its data-side memories. For each access it takes the byte address, the access size, a zero-extend flag, the store data and a load/store flag. It picks a target from the top four address bits and drives that target's enables. For a store it builds a per-byte write mask and moves the store data onto the correct lanes. For a load it takes the word that the selected memory returns one cycle later, picks the addressed byte or halfword and extends it to 32 bits.

Four kinds of target can be reached. The data memory can be read and written. The instruction memory can only be written through this port. The boot ROM can only be read. The MMIO window can be read and written. One address region writes the same store into data and instruction memory at once, so that a single image transfer can fill both. The memories, the peripherals and any trap on a misaligned access are outside this block. Every access is assumed to be naturally aligned.

Top module: `lsu_route`

## Requirements
- R1: Address bits 31:28 choose the target. 0x1 selects data memory for loads and stores. 0x2 selects instruction memory for stores only. 0x3 selects data plus instruction memory for stores and data memory for loads. 0x4 selects the boot ROM. 0x8 selects the MMIO window (`mmio_re`/`mmio_we`). Any other value drives no enable, and a load there returns 0.
- R2: A store at 0x3 drives identical nonzero masks on `dmem_we` and `imem_we`, with the same lane data on both.
- R3: A load at 0x2 returns 0 and asserts no read enable.
- R4: A store at 0x4 asserts no write enable on any port.
- R5: Size code 0 is a byte. A byte store drives mask 4'b0001 shifted left by addr[1:0], and the low byte of the store data is copied onto all four lanes.
- R6: Size code 1 is a halfword. A halfword store drives mask 4'b0011 shifted left by 2*addr[1], and the low halfword is copied onto both halves.
- R7: Size code 2 is a word. A word store drives mask 4'b1111 and passes the store data through unchanged.
- R8: For a load issued in cycle N, `load_valid` is high and `load_data` holds the result after the clock edge that ends cycle N. The result uses the read data that the selected target presents in cycle N+1. In every other cycle `load_valid` is low.
- R9: A byte load returns bits [8*addr[1:0] +: 8] of the returned word. They are sign-extended when `acc_unsigned` is 0 and zero-extended when it is 1.
- R10: A halfword load returns bits [16*addr[1] +: 16], extended in the same way as a byte load.
- R11: The data and instruction word address is addr[15:2], the ROM word address is addr[13:2] and the MMIO byte offset is addr[7:0].
- R12: While reset is active and directly after it, `load_valid` is 0 and `load_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Byte address |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_unsigned | input | 1 | 1 = zero-extend a narrow load |
| acc_wdata | input | 32 | Store data, right-justified |
| dmem_en | output | 1 | Data memory enable |
| dmem_we | output | 4 | Data memory byte write mask |
| dmem_addr | output | 14 | Data memory word address |
| dmem_wdata | output | 32 | Data memory lane data |
| dmem_rdata | input | 32 | Data memory read word (one cycle later) |
| imem_we | output | 4 | Instruction memory byte write mask |
| imem_addr | output | 14 | Instruction memory word address |
| imem_wdata | output | 32 | Instruction memory lane data |
| rom_en | output | 1 | Boot ROM read enable |
| rom_addr | output | 12 | Boot ROM word address |
| rom_rdata | input | 32 | Boot ROM read word (one cycle later) |
| mmio_re | output | 1 | MMIO read strobe |
| mmio_we | output | 1 | MMIO write strobe |
| mmio_be | output | 4 | MMIO byte mask |
| mmio_addr | output | 8 | MMIO byte offset |
| mmio_wdata | output | 32 | MMIO lane data |
| mmio_rdata | input | 32 | MMIO read word (one cycle later) |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Aligned and extended load result |

## Verification
The assertions assume that every access is naturally aligned and that `acc_size` is never 3. The lane-mask properties for halfwords only hold when addr[0] is 0. They also assume that each target returns its read word exactly one cycle after the request. The stimulus uses only aligned addresses and the sizes 0 to 2. It holds each read-data input at a fixed, distinct pattern, so the bench can tell which source a load used. Loads and stores are driven back to back, and each goes to one of the named regions or to an unused region.

// File: rtl/lsu_route_pkg.sv
// Shared types for the load/store router: target codes, size codes and the
// context carried from the request cycle into the load-return cycle.
package lsu_route_pkg;

    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_DMEM = 3'd1,
        TGT_IMEM = 3'd2,
        TGT_BOTH = 3'd3,
        TGT_ROM  = 3'd4,
        TGT_MMIO = 3'd5
    } tgt_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef struct packed {
        logic       valid;
        tgt_e       tgt;
        logic [1:0] lo;
        size_e      size;
        logic       uns;
    } ld_ctx_t;

endpackage

// File: rtl/lsu_region_dec.sv
// Region decoder: maps the top address nibble to a target code.
// Assumes the nibble codes given as parameters are all distinct.
module lsu_region_dec
    import lsu_route_pkg::*;
#(
    parameter logic [3:0] DMEM_NIB = 4'h1,
    parameter logic [3:0] IMEM_NIB = 4'h2,
    parameter logic [3:0] BOTH_NIB = 4'h3,
    parameter logic [3:0] ROM_NIB  = 4'h4,
    parameter logic [3:0] MMIO_NIB = 4'h8
) (
    input  logic [3:0] nib,
    output tgt_e       tgt
);

    // Compare the nibble against each region code.
    always_comb begin
        if (nib == DMEM_NIB)      tgt = TGT_DMEM;
        else if (nib == IMEM_NIB) tgt = TGT_IMEM;
        else if (nib == BOTH_NIB) tgt = TGT_BOTH;
        else if (nib == ROM_NIB)  tgt = TGT_ROM;
        else if (nib == MMIO_NIB) tgt = TGT_MMIO;
        else                      tgt = TGT_NONE;
    end

endmodule

// File: rtl/lsu_store_lanes.sv
// Store lane builder: produces the byte write mask and the lane-replicated
// store data for one access. Assumes natural alignment; size code 3 is
// handled as a word.
module lsu_store_lanes
    import lsu_route_pkg::*;
(
    input  logic [1:0]        lo,
    input  size_e             size,
    input  logic [WORD_W-1:0] wdata,
    output logic [LANES-1:0]  mask,
    output logic [WORD_W-1:0] data
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int HALF_IDX = g / 2;
        localparam int HALF_SUB = g % 2;

        // Pick the enable and the source byte for lane g.
        always_comb begin
            case (size)
                SZ_BYTE: begin
                    mask[g]                = (lo == 2'(g));
                    data[g*BYTE_W +: BYTE_W] = wdata[BYTE_W-1:0];
                end
                SZ_HALF: begin
                    mask[g]                = (lo[1] == 1'(HALF_IDX));
                    data[g*BYTE_W +: BYTE_W] = wdata[HALF_SUB*BYTE_W +: BYTE_W];
                end
                default: begin
                    mask[g]                = 1'b1;
                    data[g*BYTE_W +: BYTE_W] = wdata[g*BYTE_W +: BYTE_W];
                end
            endcase
        end
    end

endmodule

// File: rtl/lsu_load_align.sv
// Load aligner: registers the load context, then selects the returned word
// of the recorded target, extracts the addressed byte or halfword and
// extends it. Assumes each target returns read data one cycle after request.
module lsu_load_align
    import lsu_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ld_ctx_t           ctx_d,
    input  logic [WORD_W-1:0] dmem_rdata,
    input  logic [WORD_W-1:0] rom_rdata,
    input  logic [WORD_W-1:0] mmio_rdata,
    output logic              load_valid,
    output logic [WORD_W-1:0] load_data
);

    ld_ctx_t           ctx_q;
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] sh_b;
    logic [WORD_W-1:0] sh_h;
    logic [7:0]        b;
    logic [15:0]       h;

    // Hold the request context across the memory read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    // Choose the word returned by the recorded target.
    always_comb begin
        case (ctx_q.tgt)
            TGT_DMEM, TGT_BOTH: word = dmem_rdata;
            TGT_ROM:            word = rom_rdata;
            TGT_MMIO:           word = mmio_rdata;
            default:            word = '0;
        endcase
    end

    // Move the addressed byte and halfword down to bit 0.
    always_comb begin
        sh_b = word >> {ctx_q.lo, 3'b000};
        sh_h = word >> {ctx_q.lo[1], 4'b0000};
        b    = sh_b[7:0];
        h    = sh_h[15:0];
    end

    // Extend the narrow value and gate the result with the valid bit.
    always_comb begin
        if (!ctx_q.valid) begin
            load_data = '0;
        end else begin
            case (ctx_q.size)
                SZ_BYTE: load_data = {{24{~ctx_q.uns & b[7]}}, b};
                SZ_HALF: load_data = {{16{~ctx_q.uns & h[15]}}, h};
                default: load_data = word;
            endcase
        end
    end

    assign load_valid = ctx_q.valid;

endmodule

// File: rtl/lsu_route.sv
// Load/store router top: decodes the target region, drives per-target
// enables, masks and lane data, and returns aligned load results one cycle
// after the request. Assumes aligned accesses and a size code of 0 to 2.
module lsu_route
    import lsu_route_pkg::*;
#(
    parameter int         MEM_BYTES  = 65536,
    parameter int         ROM_BYTES  = 16384,
    parameter int         MMIO_BYTES = 256,
    parameter logic [3:0] DMEM_NIB   = 4'h1,
    parameter logic [3:0] IMEM_NIB   = 4'h2,
    parameter logic [3:0] BOTH_NIB   = 4'h3,
    parameter logic [3:0] ROM_NIB    = 4'h4,
    parameter logic [3:0] MMIO_NIB   = 4'h8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           acc_valid,
    input  logic                           acc_store,
    input  logic [31:0]                    acc_addr,
    input  logic [1:0]                     acc_size,
    input  logic                           acc_unsigned,
    input  logic [31:0]                    acc_wdata,
    output logic                           dmem_en,
    output logic [3:0]                     dmem_we,
    output logic [$clog2(MEM_BYTES)-3:0]   dmem_addr,
    output logic [31:0]                    dmem_wdata,
    input  logic [31:0]                    dmem_rdata,
    output logic [3:0]                     imem_we,
    output logic [$clog2(MEM_BYTES)-3:0]   imem_addr,
    output logic [31:0]                    imem_wdata,
    output logic                           rom_en,
    output logic [$clog2(ROM_BYTES)-3:0]   rom_addr,
    input  logic [31:0]                    rom_rdata,
    output logic                           mmio_re,
    output logic                           mmio_we,
    output logic [3:0]                     mmio_be,
    output logic [$clog2(MMIO_BYTES)-1:0]  mmio_addr,
    output logic [31:0]                    mmio_wdata,
    input  logic [31:0]                    mmio_rdata,
    output logic                           load_valid,
    output logic [31:0]                    load_data
);

    localparam int MEM_AW  = $clog2(MEM_BYTES) - 2;
    localparam int ROM_AW  = $clog2(ROM_BYTES) - 2;
    localparam int MMIO_AW = $clog2(MMIO_BYTES);

    tgt_e              tgt;
    size_e             sz;
    logic [LANES-1:0]  mask;
    logic [WORD_W-1:0] lane_data;
    logic              is_ld;
    logic              is_st;
    logic              dm_hit;
    logic              im_hit;
    ld_ctx_t           ctx_d;
    logic              unused_addr_bits;

    assign sz = size_e'(acc_size);

    lsu_region_dec #(
        .DMEM_NIB (DMEM_NIB),
        .IMEM_NIB (IMEM_NIB),
        .BOTH_NIB (BOTH_NIB),
        .ROM_NIB  (ROM_NIB),
        .MMIO_NIB (MMIO_NIB)
    ) u_dec (
        .nib (acc_addr[31:28]),
        .tgt (tgt)
    );

    lsu_store_lanes u_lanes (
        .lo    (acc_addr[1:0]),
        .size  (sz),
        .wdata (acc_wdata),
        .mask  (mask),
        .data  (lane_data)
    );

    // Classify the request and the memories it reaches.
    always_comb begin
        is_ld  = acc_valid & ~acc_store;
        is_st  = acc_valid & acc_store;
        dm_hit = (tgt == TGT_DMEM) || (tgt == TGT_BOTH);
        im_hit = (tgt == TGT_IMEM) || (tgt == TGT_BOTH);
    end

    // Drive the per-target enables, masks and addresses.
    always_comb begin
        dmem_en    = acc_valid & dm_hit;
        dmem_we    = (is_st & dm_hit) ? mask : '0;
        imem_we    = (is_st & im_hit) ? mask : '0;
        rom_en     = is_ld & (tgt == TGT_ROM);
        mmio_re    = is_ld & (tgt == TGT_MMIO);
        mmio_we    = is_st & (tgt == TGT_MMIO);
        mmio_be    = mmio_we ? mask : '0;
        dmem_addr  = acc_addr[MEM_AW+1:2];
        imem_addr  = acc_addr[MEM_AW+1:2];
        rom_addr   = acc_addr[ROM_AW+1:2];
        mmio_addr  = acc_addr[MMIO_AW-1:0];
        dmem_wdata = lane_data;
        imem_wdata = lane_data;
        mmio_wdata = lane_data;
    end

    // Pack the context the aligner needs in the return cycle.
    always_comb begin
        ctx_d.valid = is_ld;
        ctx_d.tgt   = tgt;
        ctx_d.lo    = acc_addr[1:0];
        ctx_d.size  = sz;
        ctx_d.uns   = acc_unsigned;
    end

    assign unused_addr_bits = ^acc_addr[27:MEM_AW+2];

    lsu_load_align u_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctx_d      (ctx_d),
        .dmem_rdata (dmem_rdata),
        .rom_rdata  (rom_rdata),
        .mmio_rdata (mmio_rdata),
        .load_valid (load_valid),
        .load_data  (load_data)
    );

endmodule

// File: rtl/lsu_route_chk.sv
// Property checker for lsu_route, attached by bind. Assumes aligned
// requests with size codes 0 to 2.
module lsu_route_chk #(
    parameter logic [3:0] DMEM_NIB = 4'h1,
    parameter logic [3:0] IMEM_NIB = 4'h2,
    parameter logic [3:0] BOTH_NIB = 4'h3,
    parameter logic [3:0] ROM_NIB  = 4'h4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_store,
    input logic [31:0] acc_addr,
    input logic [1:0]  acc_size,
    input logic [3:0]  dmem_we,
    input logic [3:0]  imem_we,
    input logic        mmio_we,
    input logic        load_valid,
    input logic [31:0] load_data
);

    assert_rom_store_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_store && acc_addr[31:28] == ROM_NIB)
        |-> (dmem_we == 4'b0 && imem_we == 4'b0 && !mmio_we));

    assert_dual_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_store && acc_addr[31:28] == BOTH_NIB)
        |-> (dmem_we == imem_we && dmem_we != 4'b0));

    assert_byte_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_store && acc_size == 2'd0 && acc_addr[31:28] == DMEM_NIB)
        |-> ($countones(dmem_we) == 1 && dmem_we[acc_addr[1:0]]));

    assert_half_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_store && acc_size == 2'd1 && acc_addr[31:28] == DMEM_NIB)
        |-> (dmem_we == (acc_addr[1] ? 4'b1100 : 4'b0011)));

    assert_load_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_store) |=> load_valid);

    assert_no_stray_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_store) |=> !load_valid);

    assert_imem_unreadable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_store && acc_addr[31:28] == IMEM_NIB) |=> (load_data == 32'h0));

endmodule

bind lsu_route lsu_route_chk #(
    .DMEM_NIB (DMEM_NIB),
    .IMEM_NIB (IMEM_NIB),
    .BOTH_NIB (BOTH_NIB),
    .ROM_NIB  (ROM_NIB)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_store  (acc_store),
    .acc_addr   (acc_addr),
    .acc_size   (acc_size),
    .dmem_we    (dmem_we),
    .imem_we    (imem_we),
    .mmio_we    (mmio_we),
    .load_valid (load_valid),
    .load_data  (load_data)
);

// File: tb/lsu_route_tb.sv
`timescale 1ns/1ps
// Scoreboard bench for lsu_route: the load driver queues expected results,
// a monitor pops and compares them when load_valid appears. Store outputs
// are checked in the request cycle.
module lsu_route_tb;

    localparam logic [31:0] DM_WORD = 32'hC3A5_7F81;
    localparam logic [31:0] RM_WORD = 32'h0B7E_9A46;
    localparam logic [31:0] MM_WORD = 32'h55AA_F00F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_store = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic        acc_unsigned = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic        dmem_en;
    logic [3:0]  dmem_we;
    logic [13:0] dmem_addr;
    logic [31:0] dmem_wdata;
    logic [3:0]  imem_we;
    logic [13:0] imem_addr;
    logic [31:0] imem_wdata;
    logic        rom_en;
    logic [11:0] rom_addr;
    logic        mmio_re;
    logic        mmio_we;
    logic [3:0]  mmio_be;
    logic [7:0]  mmio_addr;
    logic [31:0] mmio_wdata;
    logic        load_valid;
    logic [31:0] load_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    lsu_route u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_store(acc_store),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_unsigned(acc_unsigned),
        .acc_wdata(acc_wdata), .dmem_en(dmem_en), .dmem_we(dmem_we),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(DM_WORD),
        .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
        .rom_en(rom_en), .rom_addr(rom_addr), .rom_rdata(RM_WORD),
        .mmio_re(mmio_re), .mmio_we(mmio_we), .mmio_be(mmio_be),
        .mmio_addr(mmio_addr), .mmio_wdata(mmio_wdata), .mmio_rdata(MM_WORD),
        .load_valid(load_valid), .load_data(load_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected narrow-load result, built from R9 and R10.
    function automatic logic [31:0] ext(input logic [31:0] w, input logic [1:0] lo,
                                        input logic [1:0] sz, input logic uns);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[8*lo +: 8];
        h = lo[1] ? w[31:16] : w[15:0];
        if (sz == 2'd0) return uns ? {24'h0, b} : {{24{b[7]}}, b};
        if (sz == 2'd1) return uns ? {16'h0, h} : {{16{h[15]}}, h};
        return w;
    endfunction

    task automatic drive(input logic st, input logic [31:0] a, input logic [1:0] sz,
                         input logic uns, input logic [31:0] wd);
        @(negedge clk);
        acc_valid = 1'b1; acc_store = st; acc_addr = a;
        acc_size = sz; acc_unsigned = uns; acc_wdata = wd;
        #1;
    endtask

    task automatic do_load(input string tag, input logic [31:0] a, input logic [1:0] sz,
                           input logic uns, input logic [31:0] exp);
        drive(1'b0, a, sz, uns, 32'h0);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0; acc_store = 1'b0;
    endtask

    // Monitor: compare each returned load with the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && load_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R8 unexpected load_valid", 32'h1, 32'h0);
                end else begin
                    chk(tag_q.pop_front(), load_data, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R12 load_valid in reset", {31'h0, load_valid}, 32'h0);
        chk("R12 load_data in reset", load_data, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R12 load_valid after reset", {31'h0, load_valid}, 32'h0);

        // Stores: outputs checked in the request cycle.
        drive(1'b1, 32'h1000_0123, 2'd0, 1'b0, 32'h0000_115A);
        chk("R5 byte mask", {28'h0, dmem_we}, 32'h8);
        chk("R5 byte lanes", dmem_wdata, 32'h5A5A_5A5A);
        chk("R11 dmem word addr", {18'h0, dmem_addr}, 32'h48);
        chk("R1 dmem store no imem", {28'h0, imem_we}, 32'h0);
        drive(1'b1, 32'h1000_0002, 2'd1, 1'b0, 32'h1234_BEEF);
        chk("R6 half mask upper", {28'h0, dmem_we}, 32'hC);
        chk("R6 half lanes", dmem_wdata, 32'hBEEF_BEEF);
        drive(1'b1, 32'h1000_0010, 2'd1, 1'b0, 32'h0000_A55A);
        chk("R6 half mask lower", {28'h0, dmem_we}, 32'h3);
        drive(1'b1, 32'h1000_0020, 2'd2, 1'b0, 32'hDEAD_C0DE);
        chk("R7 word mask", {28'h0, dmem_we}, 32'hF);
        chk("R7 word data", dmem_wdata, 32'hDEAD_C0DE);
        drive(1'b1, 32'h3000_0041, 2'd0, 1'b0, 32'h0000_0077);
        chk("R2 dual dmem mask", {28'h0, dmem_we}, 32'h2);
        chk("R2 dual imem mask", {28'h0, imem_we}, 32'h2);
        chk("R2 dual imem data", imem_wdata, 32'h7777_7777);
        chk("R2 dual imem addr", {18'h0, imem_addr}, 32'h10);
        drive(1'b1, 32'h2000_0100, 2'd2, 1'b0, 32'h0BAD_F00D);
        chk("R1 imem only imem_we", {28'h0, imem_we}, 32'hF);
        chk("R1 imem only dmem_we", {27'h0, dmem_en, dmem_we}, 32'h0);
        drive(1'b1, 32'h4000_0004, 2'd2, 1'b0, 32'hFFFF_FFFF);
        chk("R4 rom store ignored", {22'h0, rom_en, mmio_we, mmio_be, dmem_we, imem_we}, 32'h0);
        drive(1'b1, 32'h8000_0009, 2'd0, 1'b0, 32'h0000_0041);
        chk("R1 mmio store strobe", {27'h0, mmio_we, mmio_be}, 32'h12);
        chk("R11 mmio offset", {24'h0, mmio_addr}, 32'h09);
        drive(1'b1, 32'h7000_0000, 2'd2, 1'b0, 32'h1111_1111);
        chk("R1 unused store", {22'h0, dmem_en, mmio_we, mmio_be, dmem_we, imem_we}, 32'h0);

        // Loads, back to back.
        do_load("R9 byte lane0 signed", 32'h1000_0040, 2'd0, 1'b0, ext(DM_WORD, 2'd0, 2'd0, 1'b0));
        chk("R1 dmem load enable", {31'h0, dmem_en}, 32'h1);
        do_load("R9 byte lane0 unsigned", 32'h1000_0040, 2'd0, 1'b1, ext(DM_WORD, 2'd0, 2'd0, 1'b1));
        do_load("R9 byte lane1 signed", 32'h1000_0041, 2'd0, 1'b0, ext(DM_WORD, 2'd1, 2'd0, 1'b0));
        do_load("R9 byte lane3 signed", 32'h1000_0043, 2'd0, 1'b0, ext(DM_WORD, 2'd3, 2'd0, 1'b0));
        do_load("R10 half low signed", 32'h1000_0040, 2'd1, 1'b0, ext(DM_WORD, 2'd0, 2'd1, 1'b0));
        do_load("R10 half high signed", 32'h1000_0042, 2'd1, 1'b0, ext(DM_WORD, 2'd2, 2'd1, 1'b0));
        do_load("R10 half high unsigned", 32'h1000_0042, 2'd1, 1'b1, ext(DM_WORD, 2'd2, 2'd1, 1'b1));
        do_load("R8 dmem word", 32'h1000_FFFC, 2'd2, 1'b0, DM_WORD);
        chk("R11 dmem top word addr", {18'h0, dmem_addr}, 32'h3FFF);
        do_load("R1 dual region load reads dmem", 32'h3000_0000, 2'd2, 1'b0, DM_WORD);
        do_load("R1 rom word", 32'h4000_0108, 2'd2, 1'b0, RM_WORD);
        chk("R11 rom word addr", {19'h0, rom_en, rom_addr}, 32'h1042);
        do_load("R9 rom byte lane2", 32'h4000_0002, 2'd0, 1'b0, ext(RM_WORD, 2'd2, 2'd0, 1'b0));
        do_load("R10 mmio half signed", 32'h8000_0004, 2'd1, 1'b0, ext(MM_WORD, 2'd0, 2'd1, 1'b0));
        chk("R1 mmio read strobe", {31'h0, mmio_re}, 32'h1);
        do_load("R3 imem load zero", 32'h2000_0000, 2'd2, 1'b0, 32'h0);
        chk("R3 no read enable", {29'h0, dmem_en, rom_en, mmio_re}, 32'h0);
        do_load("R1 unused nibble 5 load", 32'h5000_0000, 2'd2, 1'b0, 32'h0);
        do_load("R1 unused nibble F load", 32'hF000_0000, 2'd0, 1'b0, 32'h0);
        idle();
        repeat (4) @(posedge clk);
        #1;
        chk("R8 all loads returned", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule